// File: doc/BRIEF.md
# Three-Channel Sample Histogram Engine

This block accumulates three independent histograms from a stream of samples, one per colour-like component. A single configuration word sets how many bins each histogram has, whether a sample lands in one bin or has its weight shared between the two bins whose centres straddle it, and whether a readback returns one bin's count or the running total up to that bin. A clear strobe empties all three histograms at once and also commits a new bin count. Results come out through a simple component-plus-index read port with one cycle of latency.

Counters are fixed point with FRAC_W fractional bits, so one whole sample is worth 2^FRAC_W counter units (16 by default). Only component 0 supports the interpolating mode. While it is active, the readback of components 1 and 2 is unspecified.

Top module: `hist3_accum`

## Requirements
- R1: After synchronous reset every counter is zero, `rd_data` is zero and the committed histogram size is 8 bins.
- R2: `cfg_word[2:0]` holds L. The number of bins is 2^L, with values below 3 treated as 3 and values above 6 treated as 6. `cfg_word[4]` selects the accumulation mode (0 nearest, 1 interpolating). `cfg_word[8]` selects the readback mode (0 single bin, 1 cumulative).
- R3: In nearest mode, each cycle with `in_valid` high and `clr` low adds 16 units to one bin in each component's own histogram. That bin's index is the top L bits of the 8-bit sample. Cycles with `in_valid` low change nothing.
- R4: In interpolating mode, take bin width W = 2^(8-L) and the centre of bin k at k*W + W/2. A component-0 sample s between centres j and j+1, at distance d = s - centre(j), adds wu = floor(16*d/W) to bin j+1 and 16 - wu to bin j.
- R5: In interpolating mode, a component-0 sample below the first centre, or at or above the last centre, adds the full 16 units to the edge bin.
- R6: A cycle with `clr` high zeroes all counters in all three histograms, and any sample presented in that same cycle is discarded.
- R7: A change to `cfg_word[2:0]` takes effect only at a cycle with `clr` high. Until then, samples keep using the previously committed bin count.
- R8: Counters saturate at 2^CNT_W - 1 and never wrap.
- R9: With `cfg_word[8]` = 0, `rd_data` in the cycle after `rd_comp`/`rd_bin` are presented equals that bin's counter, zero-extended. `rd_comp` = 0, 1 or 2 selects the component, and `rd_comp` = 3 reads zero.
- R10: With `cfg_word[8]` = 1, `rd_data` equals the sum of the selected component's counters for bins 0 through `rd_bin` inclusive, with the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty all histograms and commit the bin count |
| cfg_word | input | 9 | Configuration: [2:0] log2 bins, [4] mode, [8] readback |
| in_valid | input | 1 | Sample qualifier |
| in_c0 | input | SAMPLE_W | Component 0 sample |
| in_c1 | input | SAMPLE_W | Component 1 sample |
| in_c2 | input | SAMPLE_W | Component 2 sample |
| rd_comp | input | 2 | Component select for readback |
| rd_bin | input | 6 | Bin index for readback |
| rd_data | output | CNT_W+6 | Registered bin count or cumulative sum |

## Verification
The block has no state beyond its counters, so any corrupted counter, misrouted weight or stale bin count shows up as a mismatch at `rd_data`. It appears one cycle after that bin, or any lower bin in cumulative mode, is addressed. The bench keeps its own model of every counter and compares the read port on every clock. Directed reads are placed right after each interpolation corner, each edge sample, each clear and each saturation event, so an error is seen within two cycles of the stimulus that caused it.

// File: rtl/hist3_pkg.sv
package hist3_pkg;
  localparam int MIN_LOG2 = 3;
  localparam int MAX_LOG2 = 6;

  typedef struct packed {
    logic [2:0] log2n;
    logic       lin;
    logic       cum;
  } hcfg_t;

  function automatic hcfg_t decode_cfg(input logic [8:0] w);
    hcfg_t r;
    if (w[2:0] < 3'(MIN_LOG2))      r.log2n = 3'(MIN_LOG2);
    else if (w[2:0] > 3'(MAX_LOG2)) r.log2n = 3'(MAX_LOG2);
    else                            r.log2n = w[2:0];
    r.lin = w[4];
    r.cum = w[8];
    return r;
  endfunction
endpackage

// File: rtl/hist3_bin_map.sv
module hist3_bin_map #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  parameter int IDX_W    = 6,
  parameter bit LIN_EN   = 1'b1
) (
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [2:0]          log2n,
  input  logic                lin,
  output logic [IDX_W-1:0]    lo_idx,
  output logic [IDX_W-1:0]    hi_idx,
  output logic [FRAC_W:0]     lo_w,
  output logic [FRAC_W:0]     hi_w
);
  localparam int WW = SAMPLE_W + FRAC_W + 1;
  localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;

  logic [WW-1:0] sv, sh, binv, pos, half, lastv, j, d, wu;
  logic          interior;

  always_comb begin
    sv    = WW'(smp);
    sh    = WW'(SAMPLE_W) - WW'(log2n);
    binv  = sv >> sh;
    pos   = sv - (binv << sh);
    half  = WW'(1) << (sh - WW'(1));
    lastv = (WW'(1) << log2n) - WW'(1);
    j        = binv;
    d        = '0;
    interior = 1'b0;
    if (pos < half) begin
      if (binv != '0) begin
        j        = binv - WW'(1);
        d        = pos + half;
        interior = 1'b1;
      end
    end else if (binv != lastv) begin
      j        = binv;
      d        = pos - half;
      interior = 1'b1;
    end
    wu = (d << FRAC_W) >> sh;

    lo_idx = binv[IDX_W-1:0];
    hi_idx = binv[IDX_W-1:0];
    lo_w   = ONE;
    hi_w   = '0;
    if (LIN_EN && lin && interior) begin
      lo_idx = j[IDX_W-1:0];
      hi_idx = IDX_W'(j + WW'(1));
      hi_w   = wu[FRAC_W:0];
      lo_w   = ONE - wu[FRAC_W:0];
    end
  end
endmodule

// File: rtl/hist3_bank.sv
module hist3_bank #(
  parameter int NBINS  = 64,
  parameter int IDX_W  = 6,
  parameter int CW     = 20,
  parameter int FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  upd,
  input  logic [IDX_W-1:0]      lo_idx,
  input  logic [IDX_W-1:0]      hi_idx,
  input  logic [FRAC_W:0]       lo_w,
  input  logic [FRAC_W:0]       hi_w,
  output logic [NBINS*CW-1:0]   cnt_flat
);
  localparam logic [CW:0] CMAX = {1'b0, {CW{1'b1}}};

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic [CW-1:0]   cnt_q;
    logic [FRAC_W+1:0] inc;
    logic [CW:0]     sum;

    always_comb begin
      inc = ((lo_idx == IDX_W'(b)) ? {1'b0, lo_w} : '0)
          + ((hi_idx == IDX_W'(b)) ? {1'b0, hi_w} : '0);
      sum = {1'b0, cnt_q} + (CW+1)'(inc);
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q <= '0;
      end else if (upd && (inc != '0)) begin
        cnt_q <= (sum > CMAX) ? {CW{1'b1}} : sum[CW-1:0];
      end
    end

    assign cnt_flat[b*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/hist3_readout.sv
module hist3_readout #(
  parameter int NBINS = 64,
  parameter int IDX_W = 6,
  parameter int CW    = 20,
  parameter int OUT_W = CW + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3*NBINS*CW-1:0] cnt_all,
  input  logic [1:0]            rd_comp,
  input  logic [IDX_W-1:0]      rd_bin,
  input  logic                  cum,
  output logic [OUT_W-1:0]      rd_data
);
  localparam int BW = NBINS * CW;

  logic [BW-1:0]    sel;
  logic [OUT_W-1:0] acc, single;

  always_comb begin
    case (rd_comp)
      2'd0:    sel = cnt_all[0*BW +: BW];
      2'd1:    sel = cnt_all[1*BW +: BW];
      2'd2:    sel = cnt_all[2*BW +: BW];
      default: sel = '0;
    endcase
    single = OUT_W'(sel[rd_bin*CW +: CW]);
    acc    = '0;
    for (int i = 0; i < NBINS; i++) begin
      if (IDX_W'(i) <= rd_bin) acc = acc + OUT_W'(sel[i*CW +: CW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= cum ? acc : single;
  end
endmodule

// File: rtl/hist3_accum.sv
module hist3_accum #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  parameter int CNT_W    = 20
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  clr,
  input  logic [8:0]                            cfg_word,
  input  logic                                  in_valid,
  input  logic [SAMPLE_W-1:0]                   in_c0,
  input  logic [SAMPLE_W-1:0]                   in_c1,
  input  logic [SAMPLE_W-1:0]                   in_c2,
  input  logic [1:0]                            rd_comp,
  input  logic [hist3_pkg::MAX_LOG2-1:0]        rd_bin,
  output logic [CNT_W+hist3_pkg::MAX_LOG2-1:0]  rd_data
);
  import hist3_pkg::*;

  localparam int IDX_W = MAX_LOG2;
  localparam int NBINS = 1 << IDX_W;
  localparam int OUT_W = CNT_W + IDX_W;

  hcfg_t cfg;
  logic [2:0] act_log2;
  logic [3*NBINS*CNT_W-1:0] cnt_flat;
  logic [3*SAMPLE_W-1:0] smp_all;

  assign cfg     = decode_cfg(cfg_word);
  assign smp_all = {in_c2, in_c1, in_c0};

  always_ff @(posedge clk) begin
    if (rst)      act_log2 <= 3'(MIN_LOG2);
    else if (clr) act_log2 <= cfg.log2n;
  end

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [IDX_W-1:0] lo_idx, hi_idx;
    logic [FRAC_W:0]  lo_w, hi_w;

    hist3_bin_map #(
      .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .LIN_EN(c == 0)
    ) u_map (
      .smp(smp_all[c*SAMPLE_W +: SAMPLE_W]), .log2n(act_log2), .lin(cfg.lin),
      .lo_idx(lo_idx), .hi_idx(hi_idx), .lo_w(lo_w), .hi_w(hi_w)
    );

    hist3_bank #(
      .NBINS(NBINS), .IDX_W(IDX_W), .CW(CNT_W), .FRAC_W(FRAC_W)
    ) u_bank (
      .clk(clk), .rst(rst), .clr(clr), .upd(in_valid),
      .lo_idx(lo_idx), .hi_idx(hi_idx), .lo_w(lo_w), .hi_w(hi_w),
      .cnt_flat(cnt_flat[c*NBINS*CNT_W +: NBINS*CNT_W])
    );
  end

  hist3_readout #(
    .NBINS(NBINS), .IDX_W(IDX_W), .CW(CNT_W), .OUT_W(OUT_W)
  ) u_rd (
    .clk(clk), .rst(rst), .cnt_all(cnt_flat), .rd_comp(rd_comp),
    .rd_bin(rd_bin), .cum(cfg.cum), .rd_data(rd_data)
  );
endmodule

// File: rtl/hist3_accum_chk.sv
module hist3_accum_chk #(
  parameter int NBINS = 64,
  parameter int CW    = 20,
  parameter int OUT_W = 26
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr,
  input logic                  in_valid,
  input logic [2:0]            act_log2,
  input logic [3*NBINS*CW-1:0] cnt_flat,
  input logic [1:0]            rd_comp,
  input logic [OUT_W-1:0]      rd_data
);
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_flat == '0));

  assert_width_held_R7: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(act_log2));

  assert_width_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (act_log2 >= 3'd3) && (act_log2 <= 3'd6));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> $stable(cnt_flat));

  assert_bad_comp_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_comp == 2'd3) |=> (rd_data == '0));

  for (genvar i = 0; i < 3*NBINS; i++) begin : g_mono
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (cnt_flat[i*CW +: CW] >= $past(cnt_flat[i*CW +: CW])));
  end
endmodule

bind hist3_accum hist3_accum_chk #(
  .NBINS(NBINS), .CW(CNT_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .act_log2(act_log2),
  .cnt_flat(cnt_flat), .rd_comp(rd_comp), .rd_data(rd_data)
);

// File: tb/hist3_accum_test.sv
`timescale 1ns/1ps
module hist3_accum_test;
  localparam int CW   = 10;
  localparam int OW   = CW + 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, clr = 1'b0, in_valid = 1'b0;
  logic [8:0]    cfg_word = 9'h003;
  logic [7:0]    in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic [1:0]    rd_comp = '0;
  logic [5:0]    rd_bin = '0;
  logic [OW-1:0] rd_data;

  hist3_accum #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_word(cfg_word), .in_valid(in_valid),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .rd_comp(rd_comp),
    .rd_bin(rd_bin), .rd_data(rd_data)
  );

  int    ref_c[3][64];
  int    ref_l2 = 3;
  bit    taint = 0;
  int    exp_q = 0;
  bit    exp_ok = 0;
  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic void add_sat(int comp, int bin, int w);
    ref_c[comp][bin] = (ref_c[comp][bin] + w > MAXC) ? MAXC : ref_c[comp][bin] + w;
  endfunction

  function automatic void apply(int comp, int s, bit lin);
    int wid, n, t, j, d, wu;
    wid = 1 << (8 - ref_l2);
    n   = 1 << ref_l2;
    if (!lin) begin
      add_sat(comp, s / wid, 16);
      return;
    end
    t = s - wid / 2;
    if (t < 0) begin
      add_sat(comp, 0, 16);
    end else begin
      j = t / wid;
      if (j >= n - 1) add_sat(comp, n - 1, 16);
      else begin
        d  = t - j * wid;
        wu = (d * 16) / wid;
        add_sat(comp, j, 16 - wu);
        add_sat(comp, j + 1, wu);
      end
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (ref_c[c, b]) ref_c[c][b] = 0;
      ref_l2 = 3; taint = 0; exp_q = 0; exp_ok = 1;
    end else begin
      if (rd_comp == 2'd3) exp_q = 0;
      else if (cfg_word[8]) begin
        exp_q = 0;
        for (int b = 0; b <= int'(rd_bin); b++) exp_q += ref_c[rd_comp][b];
      end else exp_q = ref_c[rd_comp][rd_bin];
      exp_ok = !(taint && (rd_comp == 2'd1 || rd_comp == 2'd2));
      if (clr) begin
        foreach (ref_c[c, b]) ref_c[c][b] = 0;
        ref_l2 = (cfg_word[2:0] < 3) ? 3 : (cfg_word[2:0] > 6) ? 6 : int'(cfg_word[2:0]);
        taint = 0;
      end else if (in_valid) begin
        apply(0, in_c0, cfg_word[4]);
        apply(1, in_c1, 1'b0);
        apply(2, in_c2, 1'b0);
        if (cfg_word[4]) taint = 1;
      end
    end
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !finished && exp_ok) chk(cur_req, int'(rd_data), exp_q);
  end

  task automatic send(int a, int b, int c);
    @(negedge clk);
    in_valid = 1'b1; in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clr(logic [8:0] cfg);
    @(negedge clk);
    cfg_word = cfg; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic rd_chk(int comp, int bin, int exp, string tag);
    @(negedge clk);
    rd_comp = 2'(comp); rd_bin = 6'(bin);
    @(negedge clk);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic sweep(int comp);
    for (int b = 0; b < 64; b++) begin
      @(negedge clk);
      rd_comp = 2'(comp); rd_bin = 6'(b);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk("R1", int'(rd_data), 0);
    rd_chk(0, 0, 0, "R1");
    cfg_word = 9'h103;
    rd_chk(2, 7, 0, "R1");
    cfg_word = 9'h003;

    // R3 nearest accumulation, per component
    cur_req = "R3";
    send(8'h00, 8'hFF, 8'h40);
    repeat (2) @(negedge clk);
    send(8'h1F, 8'h20, 8'h40);
    rd_chk(0, 0, 32, "R3");
    rd_chk(1, 7, 16, "R3");
    rd_chk(2, 2, 32, "R3");
    for (int c = 0; c < 3; c++) sweep(c);

    // R9 plain readout and unused component select
    cur_req = "R9";
    rd_chk(3, 0, 0, "R9");
    rd_chk(1, 1, 16, "R9");

    // R10 cumulative readout
    cur_req = "R10";
    cfg_word = 9'h103;
    rd_chk(0, 7, 32, "R10");
    rd_chk(1, 3, 16, "R10");
    rd_chk(2, 1, 0, "R10");
    sweep(2);

    // R7 bin count committed only on clear
    cur_req = "R7";
    cfg_word = 9'h004;
    do_clr(9'h003);
    cfg_word = 9'h004;
    send(8'h30, 0, 0);
    rd_chk(0, 1, 16, "R7");
    rd_chk(0, 3, 0, "R7");
    cur_req = "R6";
    do_clr(9'h004);
    rd_chk(0, 1, 0, "R6");
    rd_chk(1, 0, 0, "R6");
    cur_req = "R7";
    send(8'h30, 0, 0);
    rd_chk(0, 3, 16, "R7");

    // R2 field decode and clamping
    cur_req = "R2";
    do_clr(9'h007);
    send(8'hFF, 8'h04, 0);
    rd_chk(0, 63, 16, "R2");
    rd_chk(1, 1, 16, "R2");
    do_clr(9'h000);
    send(8'hFF, 0, 0);
    rd_chk(0, 7, 16, "R2");

    // R4 interpolating weights
    cur_req = "R4";
    do_clr(9'h013);
    send(100, 0, 0);
    rd_chk(0, 2, 6, "R4");
    rd_chk(0, 3, 10, "R4");
    do_clr(9'h016);
    send(10, 0, 0);
    rd_chk(0, 2, 16, "R4");
    rd_chk(0, 3, 0, "R4");
    send(11, 0, 0);
    rd_chk(0, 2, 28, "R4");
    rd_chk(0, 3, 4, "R4");
    cur_req = "R10";
    cfg_word = 9'h116;
    rd_chk(0, 3, 32, "R10");

    // R5 edge samples
    cur_req = "R5";
    do_clr(9'h013);
    send(5, 0, 0);
    send(250, 0, 0);
    send(16, 0, 0);
    rd_chk(0, 0, 32, "R5");
    rd_chk(0, 7, 16, "R5");
    rd_chk(0, 1, 0, "R5");

    // R6 clear wins over a same-cycle sample
    cur_req = "R6";
    do_clr(9'h003);
    send(0, 0, 0);
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_c0 = 8'h00;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    rd_chk(0, 0, 0, "R6");

    // R8 saturation
    cur_req = "R8";
    for (int k = 0; k < 70; k++) send(0, 0, 0);
    rd_chk(0, 0, MAXC, "R8");
    rd_chk(1, 0, MAXC, "R8");
    cur_req = "R10";
    cfg_word = 9'h103;
    rd_chk(0, 7, MAXC, "R10");

    // mixed traffic against the model
    cur_req = "R4";
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk);
      in_valid = 1'($urandom);
      in_c0 = 8'($urandom); in_c1 = 8'($urandom); in_c2 = 8'($urandom);
      rd_comp = 2'($urandom); rd_bin = 6'($urandom);
      clr = (k % 200 == 0);
      if (k % 200 == 0 || k % 200 == 77)
        cfg_word = {1'($urandom), 3'b0, 1'($urandom), 1'b0, 3'(3 + $urandom % 4)};
    end
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule